// File: doc/BRIEF.md
# Bidirectional GPIO Port Controller

This block runs one general-purpose I/O port of parameterised width (eight pins by default). It holds a direction register and an output-data register on a small register bus. The bus has an address, a write strobe, a read strobe, write data and read data. For each pin the block sends an output value and an output enable to the pad logic. It samples the pin levels through a two-stage synchronizer.

A read of the data address returns a mix of two sources. Pins set as outputs return their latched value. Pins set as inputs return their synchronized level. The direction register cannot be read back: its address always returns all ones.

In two operating modes one pin, the top bit by default, becomes an address output. Its enable is forced on and it drives an external address bit. The data register bit behind that pin keeps its stored value.

Hardware standby clears both registers. Software standby freezes both registers, so every output pin keeps driving its last value.

Top module: `gpio_port_ctrl`

## Requirements
- R1: A pin whose direction bit is 1 has its output enable high. A pin whose direction bit is 0 has it low. Each pin's output value equals its data-register bit (top bit aside, see R7).
- R2: A read strobe at the direction address (offset 0) returns all ones, whatever was written there.
- R3: A read at the data address (offset 1) returns two things per bit. Where the direction bit is 1, it returns the latched data bit. Where the direction bit is 0, it returns the pin level. A pin level change is seen on the read path after exactly two rising clock edges.
- R4: A synchronous reset clears both registers to zero at the next rising edge.
- R5: While hardware standby is high, both registers are cleared at every rising edge and writes have no effect.
- R6: While software standby is high (and hardware standby low), both registers hold their contents and writes are ignored. Output enables and output values stay unchanged.
- R7: With mode input equal to 3 or 4, the top pin has its output enable forced high and drives the external address bit, whatever its direction bit holds. In other modes it follows R1.
- R8: While the top pin is overridden, data-address reads return the latched data bit at the top position. Values written to that bit are stored and drive the pin again once the override ends.
- R9: Writes to unmapped addresses (offsets 2 and 3) change nothing. Reads of unmapped addresses, and the read data whenever the read strobe is low, are zero.
- R10: A write takes effect at the rising edge where the write strobe is high. The new value is visible on the pad outputs right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hw_stby | input | 1 | Hardware standby, clears registers |
| sw_stby | input | 1 | Software standby, freezes registers |
| op_mode | input | 3 | Operating mode; 3 and 4 override the top pin |
| ext_addr_bit | input | 1 | Address bit driven on the overridden pin |
| bus_addr | input | 2 | Register offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational |
| pin_in | input | 8 | Pad input levels |
| pin_out | output | 8 | Pad output values |
| pin_oe | output | 8 | Pad output enables |

## Verification
A direction register holding the wrong value shows up at once on the output enables, in the cycle right after the edge that corrupted it. A bad data register shows up in the same cycle on the pad output values. State frozen or cleared at the wrong time shows up in the cycle after the standby edge, as enables or values that moved when they should not. A synchronizer with the wrong depth shows up as read data that changes one edge too early or too late after a pin level change. The bench samples the read data at both of those edges.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_DIR  = 2'd1,
    SEL_DAT  = 2'd2
  } reg_sel_e;

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stage_q[0] <= '0;
        else     stage_q[0] <= async_in;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stage_q[s] <= '0;
        else     stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_port_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hw_stby,
  input  logic             sw_stby,
  input  logic             wr_en,
  input  reg_sel_e         sel,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] dir_q,
  output logic [WIDTH-1:0] dat_q
);

  logic wr_ok;
  assign wr_ok = wr_en && !sw_stby;

  always_ff @(posedge clk) begin
    if (rst || hw_stby) begin
      dir_q <= '0;
      dat_q <= '0;
    end else if (wr_ok) begin
      if (sel == SEL_DIR) dir_q <= wdata;
      if (sel == SEL_DAT) dat_q <= wdata;
    end
  end

endmodule

// File: rtl/gpio_pad_drive.sv
module gpio_pad_drive #(
  parameter int WIDTH   = 8,
  parameter int OVR_BIT = 7
) (
  input  logic [WIDTH-1:0] dir_q,
  input  logic [WIDTH-1:0] dat_q,
  input  logic             ovr_en,
  input  logic             ext_addr_bit,
  output logic [WIDTH-1:0] pin_out,
  output logic [WIDTH-1:0] pin_oe
);

  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    if (i == OVR_BIT) begin : g_ovr
      assign pin_oe[i]  = ovr_en ? 1'b1 : dir_q[i];
      assign pin_out[i] = ovr_en ? ext_addr_bit : dat_q[i];
    end else begin : g_plain
      assign pin_oe[i]  = dir_q[i];
      assign pin_out[i] = dat_q[i];
    end
  end

endmodule

// File: rtl/gpio_read_mux.sv
module gpio_read_mux
  import gpio_port_pkg::*;
#(
  parameter int WIDTH   = 8,
  parameter int OVR_BIT = 7
) (
  input  logic             rd_en,
  input  reg_sel_e         sel,
  input  logic             ovr_en,
  input  logic [WIDTH-1:0] dir_q,
  input  logic [WIDTH-1:0] dat_q,
  input  logic [WIDTH-1:0] pin_sync,
  output logic [WIDTH-1:0] rdata
);

  logic [WIDTH-1:0] port_view;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    if (i == OVR_BIT) begin : g_ovr
      assign port_view[i] = (ovr_en || dir_q[i]) ? dat_q[i] : pin_sync[i];
    end else begin : g_plain
      assign port_view[i] = dir_q[i] ? dat_q[i] : pin_sync[i];
    end
  end

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      unique case (sel)
        SEL_DIR: rdata = '1;
        SEL_DAT: rdata = port_view;
        default: rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_port_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int ADDR_W      = 2,
  parameter int MODE_W      = 3,
  parameter int SYNC_STAGES = 2,
  parameter int OVR_BIT     = 7,
  parameter int DIR_OFS     = 0,
  parameter int DAT_OFS     = 1,
  parameter int OVR_MODE_A  = 3,
  parameter int OVR_MODE_B  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hw_stby,
  input  logic              sw_stby,
  input  logic [MODE_W-1:0] op_mode,
  input  logic              ext_addr_bit,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [WIDTH-1:0]  bus_wdata,
  output logic [WIDTH-1:0]  bus_rdata,
  input  logic [WIDTH-1:0]  pin_in,
  output logic [WIDTH-1:0]  pin_out,
  output logic [WIDTH-1:0]  pin_oe
);

  localparam logic [ADDR_W-1:0] DIR_A = ADDR_W'(DIR_OFS);
  localparam logic [ADDR_W-1:0] DAT_A = ADDR_W'(DAT_OFS);
  localparam logic [MODE_W-1:0] OVR_A = MODE_W'(OVR_MODE_A);
  localparam logic [MODE_W-1:0] OVR_B = MODE_W'(OVR_MODE_B);

  reg_sel_e         sel;
  logic             ovr_en;
  logic [WIDTH-1:0] dir_q;
  logic [WIDTH-1:0] dat_q;
  logic [WIDTH-1:0] pin_sync;

  always_comb begin
    if (bus_addr == DIR_A)      sel = SEL_DIR;
    else if (bus_addr == DAT_A) sel = SEL_DAT;
    else                        sel = SEL_NONE;
  end

  assign ovr_en = (op_mode == OVR_A) || (op_mode == OVR_B);

  gpio_in_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) sync_i (
    .clk      (clk),
    .rst      (rst),
    .async_in (pin_in),
    .sync_out (pin_sync)
  );

  gpio_port_regs #(.WIDTH(WIDTH)) regs_i (
    .clk     (clk),
    .rst     (rst),
    .hw_stby (hw_stby),
    .sw_stby (sw_stby),
    .wr_en   (bus_wr),
    .sel     (sel),
    .wdata   (bus_wdata),
    .dir_q   (dir_q),
    .dat_q   (dat_q)
  );

  gpio_pad_drive #(.WIDTH(WIDTH), .OVR_BIT(OVR_BIT)) pad_i (
    .dir_q        (dir_q),
    .dat_q        (dat_q),
    .ovr_en       (ovr_en),
    .ext_addr_bit (ext_addr_bit),
    .pin_out      (pin_out),
    .pin_oe       (pin_oe)
  );

  gpio_read_mux #(.WIDTH(WIDTH), .OVR_BIT(OVR_BIT)) rmux_i (
    .rd_en    (bus_rd),
    .sel      (sel),
    .ovr_en   (ovr_en),
    .dir_q    (dir_q),
    .dat_q    (dat_q),
    .pin_sync (pin_sync),
    .rdata    (bus_rdata)
  );

endmodule

// File: rtl/gpio_port_ctrl_chk.sv
module gpio_port_ctrl_chk #(
  parameter int WIDTH      = 8,
  parameter int ADDR_W     = 2,
  parameter int MODE_W     = 3,
  parameter int OVR_BIT    = 7,
  parameter int DIR_OFS    = 0,
  parameter int DAT_OFS    = 1,
  parameter int OVR_MODE_A = 3,
  parameter int OVR_MODE_B = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              hw_stby,
  input logic              sw_stby,
  input logic [MODE_W-1:0] op_mode,
  input logic              ext_addr_bit,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [WIDTH-1:0]  bus_wdata,
  input logic [WIDTH-1:0]  bus_rdata,
  input logic [WIDTH-1:0]  pin_out,
  input logic [WIDTH-1:0]  pin_oe
);

  localparam logic [WIDTH-1:0] PLAIN = ~(WIDTH'(1) << OVR_BIT);
  localparam logic [ADDR_W-1:0] DIR_A = ADDR_W'(DIR_OFS);
  localparam logic [ADDR_W-1:0] DAT_A = ADDR_W'(DAT_OFS);

  logic ovr_mode;
  assign ovr_mode = (op_mode == MODE_W'(OVR_MODE_A)) || (op_mode == MODE_W'(OVR_MODE_B));

  AST_DIR_READS_ONES: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == DIR_A) |-> (bus_rdata == '1)); // R2

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
    (!bus_rd || (bus_addr != DIR_A && bus_addr != DAT_A)) |-> (bus_rdata == '0)); // R9

  AST_TOP_PIN_OVERRIDE: assert property (@(posedge clk) disable iff (rst)
    ovr_mode |-> (pin_oe[OVR_BIT] && pin_out[OVR_BIT] == ext_addr_bit)); // R7

  AST_HW_STBY_CLEARS: assert property (@(posedge clk) disable iff (rst)
    hw_stby |=> (((pin_oe | pin_out) & PLAIN) == '0)); // R5

  AST_SW_STBY_FREEZE: assert property (@(posedge clk) disable iff (rst)
    (sw_stby && !hw_stby) |=> ($stable(pin_oe & PLAIN) && $stable(pin_out & PLAIN))); // R6

  AST_DIR_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == DIR_A && !sw_stby && !hw_stby)
      |=> ((pin_oe & PLAIN) == ($past(bus_wdata) & PLAIN))); // R10

endmodule

bind gpio_port_ctrl gpio_port_ctrl_chk #(
  .WIDTH(WIDTH), .ADDR_W(ADDR_W), .MODE_W(MODE_W), .OVR_BIT(OVR_BIT),
  .DIR_OFS(DIR_OFS), .DAT_OFS(DAT_OFS), .OVR_MODE_A(OVR_MODE_A), .OVR_MODE_B(OVR_MODE_B)
) chk_i (
  .clk(clk), .rst(rst), .hw_stby(hw_stby), .sw_stby(sw_stby), .op_mode(op_mode),
  .ext_addr_bit(ext_addr_bit), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_out(pin_out), .pin_oe(pin_oe)
);

// File: tb/gpio_port_ctrl_tb.sv
module gpio_port_ctrl_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       hw_stby = 1'b0;
  logic       sw_stby = 1'b0;
  logic [2:0] op_mode = 3'd0;
  logic       ext_addr_bit = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic [7:0] pin_in = 8'h00;
  logic [7:0] pin_out;
  logic [7:0] pin_oe;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  gpio_port_ctrl dut_i (
    .clk(clk), .rst(rst), .hw_stby(hw_stby), .sw_stby(sw_stby), .op_mode(op_mode),
    .ext_addr_bit(ext_addr_bit), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    wr(2'd0, 8'hFF); wr(2'd1, 8'hA5);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R4 oe after reset", pin_oe, 8'h00);
    check("R4 out after reset", pin_out, 8'h00);
    rd(2'd1, d); check("R4 data read after reset", d, 8'h00);
  endtask

  task automatic t_direction();
    logic [7:0] d;
    wr(2'd0, 8'hF0);
    check("R10 oe right after write", pin_oe, 8'hF0);
    wr(2'd1, 8'h5A);
    check("R1 oe follows direction", pin_oe, 8'hF0);
    check("R1 out follows data", pin_out, 8'h5A);
    rd(2'd0, d); check("R2 direction reads ones", d, 8'hFF);
  endtask

  task automatic t_mixed_read();
    logic [7:0] d;
    pin_in = 8'h3C;
    repeat (3) @(negedge clk);
    rd(2'd1, d); check("R3 mixed read", d, 8'h5C);
    @(negedge clk); pin_in = 8'hC3;
    @(negedge clk);
    bus_addr = 2'd1; bus_rd = 1'b1; #1;
    check("R3 one edge still old", bus_rdata, 8'h5C);
    @(negedge clk); #1;
    check("R3 two edges new level", bus_rdata, 8'h53);
    bus_rd = 1'b0;
  endtask

  task automatic t_unmapped();
    logic [7:0] d;
    wr(2'd2, 8'h0F); wr(2'd3, 8'hFF);
    check("R9 unmapped write oe", pin_oe, 8'hF0);
    check("R9 unmapped write out", pin_out, 8'h5A);
    rd(2'd3, d); check("R9 unmapped read", d, 8'h00);
    @(negedge clk); bus_addr = 2'd0; #1;
    check("R9 no strobe reads zero", bus_rdata, 8'h00);
  endtask

  task automatic t_hw_standby();
    logic [7:0] d;
    wr(2'd0, 8'hFF); wr(2'd1, 8'h77);
    @(negedge clk); hw_stby = 1'b1;
    @(negedge clk);
    check("R5 oe cleared", pin_oe, 8'h00);
    check("R5 out cleared", pin_out, 8'h00);
    wr(2'd0, 8'hFF);
    check("R5 write blocked", pin_oe, 8'h00);
    @(negedge clk); hw_stby = 1'b0;
    pin_in = 8'h00; repeat (3) @(negedge clk);
    rd(2'd1, d); check("R5 data stays clear", d, 8'h00);
  endtask

  task automatic t_sw_standby();
    logic [7:0] d;
    wr(2'd0, 8'h0F); wr(2'd1, 8'h96);
    @(negedge clk); sw_stby = 1'b1;
    wr(2'd0, 8'hFF); wr(2'd1, 8'h00);
    check("R6 oe held", pin_oe, 8'h0F);
    check("R6 out held", pin_out, 8'h96);
    rd(2'd1, d); check("R6 data read held", d, 8'h06);
    @(negedge clk); sw_stby = 1'b0;
    check("R6 held after release", pin_out, 8'h96);
  endtask

  task automatic t_override();
    logic [7:0] d;
    wr(2'd0, 8'h00); wr(2'd1, 8'h00);
    pin_in = 8'h00;
    @(negedge clk); op_mode = 3'd3; ext_addr_bit = 1'b1; #1;
    check("R7 mode3 oe top", pin_oe, 8'h80);
    check("R7 mode3 out top", pin_out, 8'h80);
    ext_addr_bit = 1'b0; #1;
    check("R7 follows address bit", pin_out, 8'h00);
    wr(2'd1, 8'h80);
    check("R8 pin not data", pin_out, 8'h00);
    rd(2'd1, d); check("R8 read latched top bit", d, 8'h80);
    @(negedge clk); op_mode = 3'd4; ext_addr_bit = 1'b1; #1;
    check("R7 mode4 oe top", pin_oe, 8'h80);
    @(negedge clk); op_mode = 3'd5; #1;
    check("R7 mode5 no override", pin_oe, 8'h00);
    wr(2'd0, 8'h80);
    check("R8 stored bit drives", pin_out, 8'h80);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R4 oe at start", pin_oe, 8'h00);
    check("R4 out at start", pin_out, 8'h00);
    t_reset();
    t_direction();
    t_mixed_read();
    t_unmapped();
    t_hw_standby();
    t_sw_standby();
    t_override();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule